// File: doc/BRIEF.md
# Separate-Sync Parallel Camera Capture Front-End

This block sits between a parallel image sensor and a word-wide FIFO. The sensor supplies a pixel clock, a vertical sync line, a horizontal sync line and a 12-bit data bus. The block oversamples all of these with its own system clock and qualifies pixel samples that fall inside an active line of an active frame. It emits single-cycle frame-start, frame-end, line-start and line-end pulses, and it packs the accepted pixels into 32-bit words for the FIFO.

Configuration inputs set several things. They set the active level of each sync line and which sensor clock edge samples the data. They set the pixel width, whether the pixel order inside a word is reversed, and whether acquisition starts as soon as vertical sync is active or only at its rising (frame-start) transition. They also set a one-shot mode that captures a single frame, and whether dropping the enable stops capture at once or lets the current frame finish. A state-machine clear input returns the block to idle, but only while the enable is low.

Top module: `cam_sync_capture`

## Requirements
- R1: `cfg_vs_inv` and `cfg_hs_inv` independently set the active level of vertical and horizontal sync: 0 means active high and 1 means active low.
- R2: With `cfg_edge_start`=0, an armed block starts a frame on any pixel sample that sees vertical sync active. With `cfg_edge_start`=1, it starts only on a sample where vertical sync is active and the previous sample saw it inactive. A frame already in progress at enable is therefore skipped.
- R3: When the enable is low and `cfg_frame_gate`=0, capture stops at once, with no further words or events. When the enable is low and `cfg_frame_gate`=1, a frame in progress runs to its frame end and no later frame is captured.
- R4: If `cfg_one_shot` is high when the enable first takes effect, exactly one frame is captured. The block then stays idle (`busy`=0) until the enable is dropped and raised again.
- R5: `cfg_pclk_inv`=0 samples data and syncs on the rising edge of the sensor clock, and 1 samples on the falling edge.
- R6: `cfg_width` 0 packs four 8-bit pixels (`pix_in[7:0]`) per word, with the first pixel in bits 7:0. Width 1 (10-bit, `pix_in[9:0]`) and width 2 (12-bit, `pix_in[11:0]`) pack two zero-extended pixels in 16-bit lanes, with the first pixel in bits 15:0.
- R7: With `cfg_swap`=1, the lane order is reversed, so the first pixel of a word lands in the most significant lane.
- R8: At line end, a partly filled word is emitted with its unfilled lanes zero. No word is emitted for an empty remainder.
- R9: A frame-start pulse marks the start of a frame. Line-start marks the first accepted pixel of a line, and line-end marks the first sample after it with horizontal sync inactive. Frame-end marks the first in-frame sample with vertical sync inactive. Frame-start never coincides with frame-end, and line-start never coincides with line-end.
- R10: `fsm_clear` aborts any pending frame and returns the block to idle only while the enable is low. While the enable is high it has no effect.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample the sensor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_in | input | 1 | Sensor pixel clock |
| vsync_in | input | 1 | Vertical sync from sensor |
| hsync_in | input | 1 | Horizontal sync from sensor |
| pix_in | input | PIX_W | Pixel data bus |
| cfg_en | input | 1 | Capture enable |
| cfg_frame_gate | input | 1 | 1: disabling waits for frame end; 0: disabling acts at once |
| cfg_one_shot | input | 1 | Capture a single frame per enable |
| cfg_edge_start | input | 1 | 1: start only on vertical sync rising transition |
| cfg_vs_inv | input | 1 | Vertical sync active low |
| cfg_hs_inv | input | 1 | Horizontal sync active low |
| cfg_pclk_inv | input | 1 | Sample on falling sensor clock edge |
| cfg_width | input | 2 | Pixel width: 0=8, 1=10, 2=12 bits |
| cfg_swap | input | 1 | Reverse lane order in packed words |
| fsm_clear | input | 1 | Return to idle (honoured only while disabled) |
| word_valid | output | 1 | Packed word strobe |
| word_data | output | 32 | Packed word |
| ev_frame_start | output | 1 | Frame start pulse |
| ev_frame_end | output | 1 | Frame end pulse |
| ev_line_start | output | 1 | Line start pulse |
| ev_line_end | output | 1 | Line end pulse |
| busy | output | 1 | Armed or inside a frame |

## Verification
A stuck or wrong acquisition state shows at the ports within one sensor clock period plus about four system cycles. Either frame-start never fires, words keep flowing after an immediate disable, or `busy` stays high after a one-shot frame. A packer that keeps a stale lane count corrupts the very next word, and it shows most clearly in partial-word flushes and swapped-lane layouts. Each scenario therefore compares every emitted word, and the counts of all four event kinds, against values derived from the pixels that were driven.

// File: rtl/cam_sync_capture.sv
module cam_sync_capture #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_in,
  input  logic             vsync_in,
  input  logic             hsync_in,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             cfg_en,
  input  logic             cfg_frame_gate,
  input  logic             cfg_one_shot,
  input  logic             cfg_edge_start,
  input  logic             cfg_vs_inv,
  input  logic             cfg_hs_inv,
  input  logic             cfg_pclk_inv,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_swap,
  input  logic             fsm_clear,
  output logic             word_valid,
  output logic [31:0]      word_data,
  output logic             ev_frame_start,
  output logic             ev_frame_end,
  output logic             ev_line_start,
  output logic             ev_line_end,
  output logic             busy
);
  typedef enum logic [1:0] {S_IDLE, S_ARM, S_FRAME, S_DONE} st_t;

  st_t              st;
  logic [2:0]       pclk_sr;
  logic [1:0]       vs_sr, hs_sr;
  logic [PIX_W-1:0] pix_m, pix_s;
  logic             vs_prev, in_line, os_q;
  logic [1:0]       cnt;
  logic [31:0]      acc;
  logic [15:0]      lane_val;

  wire smp      = cfg_pclk_inv ? (pclk_sr[2] & ~pclk_sr[1]) : (~pclk_sr[2] & pclk_sr[1]);
  wire vs_act   = vs_sr[1] ^ cfg_vs_inv;
  wire hs_act   = hs_sr[1] ^ cfg_hs_inv;
  wire kill     = !cfg_en && !cfg_frame_gate;
  wire clr      = fsm_clear && !cfg_en;
  wire live     = !kill && !clr;
  wire in_frame = (st == S_FRAME) && smp && live;
  wire vs_go    = cfg_edge_start ? (vs_act && !vs_prev) : vs_act;
  wire fs       = (st == S_ARM) && smp && live && cfg_en && vs_go;
  wire px       = in_frame && vs_act && hs_act;
  wire le       = in_frame && in_line && !(vs_act && hs_act);
  wire fe       = in_frame && !vs_act;

  wire       narrow = (cfg_width == 2'd0);
  wire [1:0] last   = narrow ? 2'd3 : 2'd1;
  wire [1:0] slot   = cfg_swap ? (last - cnt) : cnt;

  always_comb begin
    case (cfg_width)
      2'd0:    lane_val = {8'b0, pix_s[7:0]};
      2'd1:    lane_val = {6'b0, pix_s[9:0]};
      default: lane_val = 16'(pix_s);
    endcase
  end

  wire [31:0] lane_sh = narrow ? ({24'b0, lane_val[7:0]} << {slot, 3'b000})
                               : ({16'b0, lane_val} << {slot[0], 4'b0000});
  wire [31:0] acc_nx  = acc | lane_sh;

  assign busy = (st == S_ARM) || (st == S_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_sr <= '0; vs_sr <= '0; hs_sr <= '0; pix_m <= '0; pix_s <= '0;
      st <= S_IDLE; vs_prev <= 1'b0; in_line <= 1'b0; os_q <= 1'b0;
      cnt <= '0; acc <= '0; word_valid <= 1'b0; word_data <= '0;
      ev_frame_start <= 1'b0; ev_frame_end <= 1'b0;
      ev_line_start <= 1'b0; ev_line_end <= 1'b0;
    end else begin
      pclk_sr <= {pclk_sr[1:0], pclk_in};
      vs_sr   <= {vs_sr[0], vsync_in};
      hs_sr   <= {hs_sr[0], hsync_in};
      pix_m   <= pix_in;
      pix_s   <= pix_m;
      if (smp) vs_prev <= vs_act;

      ev_frame_start <= fs;
      ev_frame_end   <= fe;
      ev_line_start  <= px && !in_line;
      ev_line_end    <= le;
      word_valid     <= 1'b0;

      if (px) begin
        in_line <= 1'b1;
        if (cnt == last) begin
          word_data  <= acc_nx;
          word_valid <= 1'b1;
          acc <= '0;
          cnt <= '0;
        end else begin
          acc <= acc_nx;
          cnt <= cnt + 2'd1;
        end
      end else if (le) begin
        in_line <= 1'b0;
        if (cnt != 2'd0) begin
          word_data  <= acc;
          word_valid <= 1'b1;
        end
        acc <= '0;
        cnt <= '0;
      end

      if (clr) begin
        st <= S_IDLE; in_line <= 1'b0; cnt <= '0; acc <= '0; os_q <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (cfg_en) begin st <= S_ARM; os_q <= cfg_one_shot; end
          S_ARM: begin
            if (!cfg_en)  st <= S_IDLE;
            else if (fs)  st <= S_FRAME;
          end
          S_FRAME: begin
            if (kill) begin
              st <= S_IDLE; in_line <= 1'b0; cnt <= '0; acc <= '0;
            end else if (fe) begin
              if (!cfg_en)   st <= S_IDLE;
              else if (os_q) st <= S_DONE;
              else           st <= S_ARM;
            end
          end
          default: if (!cfg_en) st <= S_IDLE;
        endcase
      end
    end
  end

  AST_KILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_en && !cfg_frame_gate) |-> !word_valid && !ev_frame_start && !ev_line_start); // R3
  AST_FS_FE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_frame_start && ev_frame_end)); // R9
  AST_LS_LE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_line_start && ev_line_end)); // R9
  AST_WORD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(busy)); // R6
  AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && os_q) |-> !busy); // R4
  AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_start |-> busy); // R2
endmodule

// File: tb/cam_sync_capture_tb.sv
module cam_sync_capture_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic pclk_in = 1'b0, vsync_in = 1'b0, hsync_in = 1'b0;
  logic [11:0] pix_in = '0;
  logic cfg_en = 0, cfg_frame_gate = 0, cfg_one_shot = 0, cfg_edge_start = 0;
  logic cfg_vs_inv = 0, cfg_hs_inv = 0, cfg_pclk_inv = 0, cfg_swap = 0, fsm_clear = 0;
  logic [1:0] cfg_width = 2'd0;
  logic word_valid, ev_frame_start, ev_frame_end, ev_line_start, ev_line_end, busy;
  logic [31:0] word_data;

  cam_sync_capture #(.PIX_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .pclk_in(pclk_in), .vsync_in(vsync_in), .hsync_in(hsync_in),
    .pix_in(pix_in), .cfg_en(cfg_en), .cfg_frame_gate(cfg_frame_gate),
    .cfg_one_shot(cfg_one_shot), .cfg_edge_start(cfg_edge_start), .cfg_vs_inv(cfg_vs_inv),
    .cfg_hs_inv(cfg_hs_inv), .cfg_pclk_inv(cfg_pclk_inv), .cfg_width(cfg_width),
    .cfg_swap(cfg_swap), .fsm_clear(fsm_clear), .word_valid(word_valid),
    .word_data(word_data), .ev_frame_start(ev_frame_start), .ev_frame_end(ev_frame_end),
    .ev_line_start(ev_line_start), .ev_line_end(ev_line_end), .busy(busy));

  int n_chk = 0, n_fail = 0;
  int c_fs = 0, c_fe = 0, c_ls = 0, c_le = 0;
  logic [31:0] got[$];
  logic [31:0] expq[$];

  always @(negedge clk) if (rst_n) begin
    if (word_valid) got.push_back(word_data);
    c_fs = c_fs + int'(ev_frame_start);
    c_fe = c_fe + int'(ev_frame_end);
    c_ls = c_ls + int'(ev_line_start);
    c_le = c_le + int'(ev_line_end);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  function automatic logic [11:0] pixv(input int seed, input int i);
    return 12'((seed * 37 + i * 12'h155 + 12'h0A3) & 12'hFFF);
  endfunction

  task automatic tick(input bit va, input bit ha, input logic [11:0] d);
    vsync_in = va ^ cfg_vs_inv;
    hsync_in = ha ^ cfg_hs_inv;
    pix_in   = d;
    pclk_in  = cfg_pclk_inv;
    repeat (4) @(negedge clk);
    pclk_in  = ~cfg_pclk_inv;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 12'h000);
  endtask

  task automatic vblank(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 12'h000);
  endtask

  task automatic send_line(input int np, input int seed);
    for (int i = 0; i < np; i++) tick(1'b1, 1'b1, pixv(seed, i));
    vblank(2);
  endtask

  task automatic send_frame(input int nl, input int np, input int seed);
    idle(3); vblank(2);
    for (int l = 0; l < nl; l++) send_line(np, seed + l);
    idle(3);
  endtask

  task automatic expect_line(input int np, input int seed);
    int per, lw;
    logic [11:0] mask;
    per  = (cfg_width == 2'd0) ? 4 : 2;
    lw   = (cfg_width == 2'd0) ? 8 : 16;
    mask = (cfg_width == 2'd0) ? 12'h0FF : (cfg_width == 2'd1) ? 12'h3FF : 12'hFFF;
    for (int i = 0; i < np; i += per) begin
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < per; k++) begin
        if (i + k < np) begin
          int s;
          s = cfg_swap ? (per - 1 - k) : k;
          w = w | ({20'b0, pixv(seed, i + k) & mask} << (s * lw));
        end
      end
      expq.push_back(w);
    end
  endtask

  task automatic clear_counts();
    got.delete(); expq.delete();
    c_fs = 0; c_fe = 0; c_ls = 0; c_le = 0;
  endtask

  task automatic check_words(input string tag);
    repeat (16) @(negedge clk);
    check(got.size() == expq.size(), {tag, " word count"}, 32'(got.size()), 32'(expq.size()));
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      check(got[i] === expq[i], {tag, " word"}, got[i], expq[i]);
  endtask

  task automatic check_events(input string tag, input int fs, input int fe, input int ls, input int le);
    check(c_fs == fs, {tag, " frame starts"}, 32'(c_fs), 32'(fs));
    check(c_fe == fe, {tag, " frame ends"}, 32'(c_fe), 32'(fe));
    check(c_ls == ls, {tag, " line starts"}, 32'(c_ls), 32'(ls));
    check(c_le == le, {tag, " line ends"}, 32'(c_le), 32'(le));
  endtask

  task automatic end_test();
    cfg_en = 0; cfg_frame_gate = 0; cfg_one_shot = 0; cfg_edge_start = 0; fsm_clear = 0;
    idle(2);
    repeat (8) @(negedge clk);
    clear_counts();
  endtask

  task automatic t_reset();
    check({word_valid, ev_frame_start, ev_frame_end, ev_line_start, ev_line_end, busy} == 6'b0,
          "R11 reset outputs", {26'b0, word_valid, ev_frame_start, ev_frame_end, ev_line_start, ev_line_end, busy}, 32'h0);
    check(word_data == 32'h0, "R11 reset word_data", word_data, 32'h0);
  endtask

  task automatic t_basic8();
    cfg_width = 2'd0; cfg_swap = 0; cfg_en = 1;
    send_frame(2, 8, 1);
    expect_line(8, 1); expect_line(8, 2);
    check_words("R6 8-bit packing");
    check_events("R9 events", 1, 1, 2, 2);
    end_test();
  endtask

  task automatic t_wide();
    cfg_width = 2'd1; cfg_en = 1;
    send_frame(1, 3, 5);
    expect_line(3, 5);
    check_words("R8 10-bit with partial flush");
    end_test();
    cfg_width = 2'd2; cfg_en = 1;
    send_frame(1, 4, 9);
    expect_line(4, 9);
    check_words("R6 12-bit packing");
    end_test();
  endtask

  task automatic t_swap();
    cfg_width = 2'd0; cfg_swap = 1; cfg_en = 1;
    send_frame(1, 6, 3);
    expect_line(6, 3);
    check_words("R7 8-bit swapped with R8 partial");
    end_test();
    cfg_width = 2'd2; cfg_swap = 1; cfg_en = 1;
    send_frame(1, 2, 7);
    expect_line(2, 7);
    check_words("R7 12-bit swapped");
    end_test();
    cfg_swap = 0;
  endtask

  task automatic t_pol();
    cfg_width = 2'd0; cfg_vs_inv = 1; cfg_hs_inv = 1; cfg_pclk_inv = 1;
    idle(3); repeat (8) @(negedge clk); clear_counts();
    cfg_en = 1;
    send_frame(2, 4, 11);
    expect_line(4, 11); expect_line(4, 12);
    check_words("R1 R5 inverted syncs and falling-edge sampling");
    check_events("R1 inverted events", 1, 1, 2, 2);
    end_test();
    cfg_vs_inv = 0; cfg_hs_inv = 0; cfg_pclk_inv = 0;
    idle(3); repeat (8) @(negedge clk); clear_counts();
  endtask

  task automatic t_start();
    cfg_width = 2'd0; cfg_edge_start = 0;
    idle(2); vblank(2);
    cfg_en = 1;
    vblank(1); send_line(4, 20); send_line(4, 21); idle(3);
    expect_line(4, 20); expect_line(4, 21);
    check_words("R2 level start mid-frame");
    check_events("R2 level start", 1, 1, 2, 2);
    end_test();
    cfg_edge_start = 1;
    idle(2); vblank(2);
    cfg_en = 1;
    vblank(1); send_line(4, 22); idle(3);
    check_events("R2 edge start skips running frame", 0, 0, 0, 0);
    send_frame(1, 4, 30);
    expect_line(4, 30);
    check_words("R2 edge start next frame");
    check_events("R2 edge start", 1, 1, 1, 1);
    end_test();
  endtask

  task automatic t_stop();
    cfg_width = 2'd0; cfg_frame_gate = 0; cfg_en = 1;
    idle(3); vblank(2); send_line(4, 40);
    cfg_en = 0;
    send_line(4, 41); idle(3);
    expect_line(4, 40);
    check_words("R3 immediate stop");
    check_events("R3 immediate stop", 1, 0, 1, 1);
    check(busy == 1'b0, "R3 idle after immediate stop", {31'b0, busy}, 32'h0);
    end_test();
    cfg_frame_gate = 1; cfg_en = 1;
    idle(3); vblank(2); send_line(4, 50);
    cfg_en = 0;
    send_line(4, 51); idle(3);
    send_frame(1, 4, 52);
    expect_line(4, 50); expect_line(4, 51);
    check_words("R3 stop at frame end");
    check_events("R3 stop at frame end", 1, 1, 2, 2);
    end_test();
  endtask

  task automatic t_oneshot();
    cfg_width = 2'd0; cfg_one_shot = 1; cfg_en = 1;
    send_frame(1, 4, 60); send_frame(1, 4, 61);
    expect_line(4, 60);
    check_words("R4 one-shot single frame");
    check_events("R4 one-shot", 1, 1, 1, 1);
    check(busy == 1'b0, "R4 idle after one-shot", {31'b0, busy}, 32'h0);
    cfg_en = 0; idle(1); cfg_one_shot = 0;
    repeat (8) @(negedge clk); clear_counts();
    cfg_en = 1;
    send_frame(1, 4, 62); send_frame(1, 4, 63);
    expect_line(4, 62); expect_line(4, 63);
    check_words("R4 re-enable continuous");
    check_events("R4 re-enable", 2, 2, 2, 2);
    end_test();
  endtask

  task automatic t_clear();
    cfg_width = 2'd0; cfg_en = 1;
    idle(3); vblank(2); send_line(4, 70);
    fsm_clear = 1;
    send_line(4, 71);
    fsm_clear = 0;
    idle(3);
    expect_line(4, 70); expect_line(4, 71);
    check_words("R10 clear ignored while enabled");
    check_events("R10 clear ignored", 1, 1, 2, 2);
    end_test();
    cfg_frame_gate = 1; cfg_en = 1;
    idle(3); vblank(2); send_line(4, 80);
    cfg_en = 0; fsm_clear = 1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R10 clear while disabled idles", {31'b0, busy}, 32'h0);
    send_line(4, 81);
    fsm_clear = 0;
    idle(3);
    expect_line(4, 80);
    check_words("R10 clear aborts pending frame");
    check_events("R10 clear aborts", 1, 0, 1, 1);
    end_test();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic8();
    t_wide();
    t_swap();
    t_pol();
    t_start();
    t_stop();
    t_oneshot();
    t_clear();
    finish_run();
  end
endmodule